// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external 128K x 8 static RAM that has no clock. The host offers one read or one write at a time on a valid/ready port. The block then produces the RAM's control waveforms on registered pins. These are an active-low select, an active-high select, an active-low write strobe, an active-low output enable, and a split data bus made of an output word, a driver enable and an input word. For reads it returns the sampled byte with a one-cycle response pulse. For writes it gives the same pulse once the write has finished.

Every interval is a whole number of clock cycles. Each count is derived at elaboration from the clock period and the RAM's minimum times, all given as parameters in picoseconds. This lets a slower speed grade or a different clock be handled by changing parameters alone. The block keeps its own data driver off whenever the RAM may be driving the bus. It also forces a turnaround gap after every read before the next write may drive the bus.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request, the pins are idle: mem_sel_n=1, mem_sel=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and rsp_valid=0. req_ready is 1 once reset has been released.
- R2: One cycle after the clock edge that accepts a read (req_valid=1, req_ready=1, req_write=0), the pins show mem_sel_n=0, mem_sel=1, mem_oe_n=0, mem_we_n=1, mem_dq_oe=0, with mem_addr equal to the request address.
- R3: For a read, mem_oe_n stays low for ACC_CYC = ceil(tAA/Tclk)+1 cycles (4 by default). mem_dq_in is captured on the edge where mem_oe_n returns high. rsp_valid is high for exactly one cycle, ACC_CYC cycles after the accepting edge, with the captured byte on rsp_rdata.
- R4: For a write, from the cycle after acceptance until one cycle after mem_we_n returns high, the pins hold mem_dq_oe=1 and mem_dq_out equal to the request data. mem_oe_n is 1 throughout.
- R5: mem_we_n goes low one cycle after the data driver turns on. It stays low for exactly WP_CYC cycles, the largest of ceil(tWP/Tclk), ceil(tDW/Tclk) and ceil(tAW/Tclk) (2 by default).
- R6: While mem_we_n is low, mem_addr and mem_dq_out do not change.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0. After a read, at least TURN_CYC+1 clock edges (2 by default) pass between the edge where mem_oe_n rises and the edge where mem_dq_oe rises.
- R8: req_ready is 1 only when no request is in progress. It drops on the accepting edge and stays 0 until the response, so only one request is outstanding.
- R9: For a write, rsp_valid is high for one cycle, 2+WP_CYC cycles after the accepting edge. At that point both selects are inactive (mem_sel_n=1, mem_sel=0) and mem_dq_oe=0.
- R10: While req_valid is 0, changes on req_write, req_addr and req_wdata cause no strobe activity and leave the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid after a read |
| mem_addr | output | 17 | RAM address pins |
| mem_sel_n | output | 1 | RAM select, active low |
| mem_sel | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable of the data pad driver |
| mem_dq_in | input | 8 | Data received from the RAM |

## Verification
The hardest case to reach is a read followed at once by a write. This is the only time the data driver could turn on soon after the RAM stopped driving, so it is the case the turnaround gap exists for. The bench reaches it by raising the write request in the same cycle the read response appears. It then measures the cycles between the output enable rising and the driver enable rising. A behavioural RAM model in the bench drives the input bus only while the pins select a read and commits a byte only on the write strobe's rising edge. As a result, a strobe that is wrong, early or too short shows up as corrupted read-back data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_TURN  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_HOLD  = 3'd5
  } ctl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int ACC_CYC  = 4,
  parameter int WP_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             cnt_zero,
  output ctl_state_e       state_q,
  output ctl_state_e       state_d,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             accept,
  output logic             rd_sample,
  output logic             done
);

  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  always_comb begin
    state_d   = state_q;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    accept    = 1'b0;
    rd_sample = 1'b0;
    done      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
          end else begin
            state_d  = ST_RD_ACC;
            cnt_load = 1'b1;
            cnt_val  = ACC_LD;
          end
        end
      end
      ST_RD_ACC: begin
        if (cnt_zero) begin
          state_d   = ST_RD_TURN;
          rd_sample = 1'b1;
          done      = 1'b1;
          cnt_load  = 1'b1;
          cnt_val   = TURN_LD;
        end
      end
      ST_RD_TURN: begin
        if (cnt_zero) state_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        cnt_load = 1'b1;
        cnt_val  = WP_LD;
      end
      ST_WR_PULSE: begin
        if (cnt_zero) state_d = ST_WR_HOLD;
      end
      ST_WR_HOLD: begin
        state_d = ST_IDLE;
        done    = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // R8: a request is taken only from idle
  assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (state_q == ST_IDLE));

  // R5: the write strobe state is entered only through the setup state
  assert_pulse_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_WR_PULSE) |-> ($past(state_q) == ST_WR_SETUP));

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_e        state_d,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_sample,
  input  logic              done,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic sel_d;
  logic rd_en_d;
  logic wr_en_d;
  logic drv_d;

  always_comb begin
    sel_d   = (state_d == ST_RD_ACC)   || (state_d == ST_WR_SETUP) ||
              (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
    rd_en_d = (state_d == ST_RD_ACC);
    wr_en_d = (state_d == ST_WR_PULSE);
    drv_d   = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
              (state_d == ST_WR_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      mem_sel_n <= ~sel_d;
      mem_sel   <= sel_d;
      mem_oe_n  <= ~rd_en_d;
      mem_we_n  <= ~wr_en_d;
      mem_dq_oe <= drv_d;
      rsp_valid <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_dq_out <= '0;
    end else if (accept && req_write) begin
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (rd_sample) begin
      rsp_rdata <= mem_dq_in;
    end
  end

  // R4: data driven and RAM outputs off for the whole strobe
  assert_wr_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && mem_oe_n));

  // R6: address and data frozen while the strobe is low
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R7: never drive against the RAM's output drivers
  assert_no_contend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7: output enable high for two edges before the driver starts
  assert_turn_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n, 1) && $past(mem_oe_n, 2)));

  // R2: strobes only with both selects active
  assert_sel_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (!mem_sel_n && mem_sel));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 4000,
  parameter int T_AA_PS   = 10000,
  parameter int T_WP_PS   = 7000,
  parameter int T_DW_PS   = 5000,
  parameter int T_AW_PS   = 8000,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int ACC_CYC = ceil_div(T_AA_PS, CLK_PS) + 1;
  localparam int WP_CYC  = max3(ceil_div(T_WP_PS, CLK_PS), ceil_div(T_DW_PS, CLK_PS),
                                ceil_div(T_AW_PS, CLK_PS));
  localparam int CNT_MAX = max3(ACC_CYC, WP_CYC, TURN_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[1];

  ctl_state_e       state_q;
  ctl_state_e       state_d;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;
  logic             accept;
  logic             rd_sample;
  logic             done;

  sram_ctl_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  sram_ctl_fsm #(
    .ACC_CYC  (ACC_CYC),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .cnt_zero  (cnt_zero),
    .state_q   (state_q),
    .state_d   (state_d),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .accept    (accept),
    .rd_sample (rd_sample),
    .done      (done)
  );

  sram_ctl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .state_d    (state_d),
    .accept     (accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_sample  (rd_sample),
    .done       (done),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assign req_ready = (state_q == ST_IDLE);

  // R3 / R9: the completion pulse lasts one cycle
  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |=> !rsp_valid);

  // R8: a response always follows a busy cycle
  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> !$past(req_ready));

endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;

  // expected counts worked out from 4 ns clock: ceil(10/4)+1, max(ceil 7/4, 5/4, 8/4)
  localparam int EXP_ACC  = 4;
  localparam int EXP_WP   = 2;
  localparam int EXP_TURN = 1;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_sel_n;
  logic        mem_sel;
  logic        mem_we_n;
  logic        mem_oe_n;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;

  int n_chk;
  int n_fail;

  sram_seq_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- RAM model and pin monitor ----------------
  logic [7:0] ram [int];
  logic       prev_we_n;
  logic       prev_dq_oe;
  logic       prev_rsp;
  logic [16:0] prev_addr;
  logic [7:0]  prev_dout;
  int         we_low_run;
  int         oe_high_run;

  initial begin
    prev_we_n   = 1'b1;
    prev_dq_oe  = 1'b0;
    prev_rsp    = 1'b0;
    prev_addr   = '0;
    prev_dout   = '0;
    we_low_run  = 0;
    oe_high_run = 100;
    mem_dq_in   = 8'h3C;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) chk("R7 driver on while RAM output enabled", 1, 0);
      if (!mem_we_n) begin
        chk("R4 driver during strobe", mem_dq_oe, 1);
        chk("R4 output enable high during strobe", mem_oe_n, 1);
        if (!prev_we_n) begin
          chk("R6 address stable in strobe", mem_addr, prev_addr);
          chk("R6 data stable in strobe", mem_dq_out, prev_dout);
        end
        we_low_run++;
      end
      if (mem_we_n && !prev_we_n) begin
        chk("R5 strobe width", we_low_run, EXP_WP);
        chk("R5 selects at strobe end", {mem_sel_n, mem_sel}, 2'b01);
        chk("R4 data held after strobe", mem_dq_oe, 1);
        ram[int'(mem_addr)] = mem_dq_out;
        we_low_run = 0;
      end
      if (mem_dq_oe && !prev_dq_oe)
        chk("R7 turnaround gap", (oe_high_run >= EXP_TURN + 1) ? 1 : 0, 1);
      if (rsp_valid && prev_rsp) chk("R3 response is one pulse", 0, 1);
      oe_high_run = mem_oe_n ? oe_high_run + 1 : 0;
      if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
        mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
      else
        mem_dq_in = 8'h3C;
    end
    prev_we_n  = mem_we_n;
    prev_dq_oe = mem_dq_oe;
    prev_rsp   = rsp_valid;
    prev_addr  = mem_addr;
    prev_dout  = mem_dq_out;
  end

  // ---------------- scenario tasks (entered at a falling edge) ----------------
  task automatic do_read(input logic [16:0] a, input logic [7:0] exp, input string tag);
    int lat;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = a;
    req_wdata = 8'h00;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 selects"}, {mem_sel_n, mem_sel}, 2'b01);
    chk({tag, " R2 oe_n"}, mem_oe_n, 0);
    chk({tag, " R2 we_n"}, mem_we_n, 1);
    chk({tag, " R2 dq_oe"}, mem_dq_oe, 0);
    chk({tag, " R2 address"}, mem_addr, a);
    chk({tag, " R8 busy"}, req_ready, 0);
    lat = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (rsp_valid) begin
        lat = k;
        break;
      end
    end
    chk({tag, " R3 latency"}, lat, EXP_ACC);
    chk({tag, " R3 data"}, rsp_rdata, exp);
    chk({tag, " R3 oe_n released"}, mem_oe_n, 1);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d, input string tag);
    int lat;
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R4 driver on"}, mem_dq_oe, 1);
    chk({tag, " R4 data"}, mem_dq_out, d);
    chk({tag, " R5 setup we_n high"}, mem_we_n, 1);
    chk({tag, " R4 oe_n"}, mem_oe_n, 1);
    chk({tag, " R8 busy"}, req_ready, 0);
    lat = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (rsp_valid) begin
        lat = k;
        break;
      end
    end
    chk({tag, " R9 latency"}, lat, 2 + EXP_WP);
    chk({tag, " R9 standby selects"}, {mem_sel_n, mem_sel}, 2'b10);
    chk({tag, " R9 driver off"}, mem_dq_oe, 0);
  endtask

  task automatic test_reset;
    chk("R1 sel_n in reset", mem_sel_n, 1);
    chk("R1 sel in reset", mem_sel, 0);
    chk("R1 we_n in reset", mem_we_n, 1);
    chk("R1 oe_n in reset", mem_oe_n, 1);
    chk("R1 dq_oe in reset", mem_dq_oe, 0);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 idle pins after reset", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
  endtask

  task automatic test_basic;
    do_write(17'h00000, 8'hA5, "wr low");
    do_write(17'h1FFFF, 8'h5A, "wr top");
    do_write(17'h0AAAA, 8'hFF, "wr mid");
    do_read(17'h00000, 8'hA5, "rd low");
    do_read(17'h1FFFF, 8'h5A, "rd top");
    do_read(17'h0AAAA, 8'hFF, "rd mid");
    do_write(17'h0AAAA, 8'h00, "wr zero");
    do_read(17'h0AAAA, 8'h00, "rd zero");
  endtask

  task automatic test_turnaround;
    // R7: write raised in the same cycle the read response appears
    do_write(17'h15555, 8'h3A, "ta seed");
    do_read(17'h15555, 8'h3A, "ta rd");
    do_write(17'h15555, 8'hC3, "ta wr");
    do_read(17'h15555, 8'hC3, "ta rd back");
    do_read(17'h1FFFF, 8'h5A, "ta rd rd");
  endtask

  task automatic test_ignore;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      req_valid = 1'b0;
      req_write = 1'b1;
      req_addr  = 17'h00000 + 17'(i);
      req_wdata = 8'h11 * 8'(i + 1);
      @(negedge clk);
      chk("R10 idle strobes", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
      chk("R10 no response", rsp_valid, 0);
    end
    do_read(17'h00000, 8'hA5, "R10 untouched");
  endtask

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    test_reset;
    test_basic;
    test_turnaround;
    test_ignore;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule